// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a clocked monostable. It watches two asynchronous trigger pins, and each pin fires on the opposite edge polarity. When one of them fires, the block raises a complementary pulse pair for a number of clock cycles given by an unsigned width input. The rising-edge pin counts only while the other pin is high. The falling-edge pin counts only while the first pin is low. Each pin must be seen at its inactive level for at least one synchronized sample before it can fire again.

A mode pin selects how a trigger that arrives during a pulse is handled. In stretch mode, the trigger reloads the timer with the current width, so the output stays high and the pulse can be extended for as long as triggers keep coming. In single-shot mode, such triggers are ignored. An active-low clear drops the output combinationally, empties the timer and blocks new triggers while it is held. The trigger pins and the clear pass through synchronizer chains. The mode and width pins are treated as quasi-static configuration. There is no streaming data path, so every pin is a plain control level.

Top module: `oneshot_retrig`

## Requirements
- R1: With `fall_in` high, a low-to-high change on `rise_in` starts a pulse. Counting the edge that captures the change as the first, `pulse` goes high after the third rising clock edge. With `fall_in` low, a rise of `rise_in` has no effect.
- R2: With `rise_in` low, a high-to-low change on `fall_in` starts a pulse, with the same three-edge latency as R1. A fall of `fall_in` while `rise_in` is high has no effect, and a rise of `fall_in` never triggers.
- R3: With `retrig_en` = 1, a trigger during a pulse reloads the timer with the value on `width` at that moment. `pulse` shows no low cycle, and it ends that many cycles after the reload.
- R4: With `retrig_en` = 0, every trigger while `pulse` is high is ignored. The pulse ends exactly one width after the trigger that started it.
- R5: A pulse started with `width` = N keeps `pulse` high for exactly N clock cycles. It then returns to the quiescent state, `pulse` = 0 and `pulse_n` = 1. `pulse_n` is always the inverse of `pulse`.
- R6: Driving `clr_n` low forces `pulse` low and `pulse_n` high without waiting for a clock. It discards the running count, so no pulse reappears when clear is released. Triggers are refused while the synchronized clear is asserted.
- R7: A trigger pin held at its active level fires only once. A new trigger needs the pin to be sampled at its inactive level for at least one synchronized cycle first.
- R8: A trigger accepted with `width` = 0 produces no pulse.
- R9: `width` is sampled only when a trigger is accepted. Changing it during a pulse does not change the running pulse.
- R10: After reset, `pulse` = 0, `pulse_n` = 1 and the timer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rise_in | input | 1 | Trigger pin, fires on its rising edge while `fall_in` is high |
| fall_in | input | 1 | Trigger pin, fires on its falling edge while `rise_in` is low |
| clr_n | input | 1 | Active-low clear |
| retrig_en | input | 1 | 1 = stretch on retrigger, 0 = single-shot |
| width | input | W | Pulse length in clock cycles |
| pulse | output | 1 | Active-high pulse output |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The bench builds the block with its defaults: an 8-bit width and two synchronizer stages. Widths from 0 to 20 are therefore cheap to reach. Zero-width triggers, overlapping retriggers that change the width in mid-pulse, and a clear that arrives during a 20-cycle pulse all fit in a short run. With two stages, the three-edge trigger latency can be scheduled exactly in the scoreboard, and the clear's synchronizer window can be probed by triggering while the clear is held.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_RETRIG = 1'b1
  } os_mode_e;

  localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/os_trig_detect.sv
module os_trig_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_s,
  input  logic fall_s,
  input  logic enable,
  output logic hit
);
  // The previous samples reset to each pin's active level, so a pin that
  // is already active when reset is released does not fire.
  logic rise_d, fall_d;
  logic hit_rise, hit_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_d <= 1'b1;
      fall_d <= 1'b0;
    end else begin
      rise_d <= rise_s;
      fall_d <= fall_s;
    end
  end

  // Each edge is qualified by the level of the other pin.
  assign hit_rise = rise_s & ~rise_d & fall_s;
  assign hit_fall = ~fall_s & fall_d & ~rise_s;
  assign hit      = enable & (hit_rise | hit_fall);
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer
  import oneshot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_ok,
  input  logic         hit,
  input  os_mode_e     mode,
  input  logic [W-1:0] width,
  output logic         accept,
  output logic         active,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  assign active = (cnt != ZERO);
  assign accept = hit & clr_ok & ((mode == MODE_RETRIG) | ~active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= ZERO;
    else if (!clr_ok) cnt <= ZERO;
    else if (accept)  cnt <= width;
    else if (active)  cnt <= cnt - ONE;
  end
endmodule

// File: rtl/oneshot_retrig.sv
module oneshot_retrig
  import oneshot_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_in,
  input  logic         fall_in,
  input  logic         clr_n,
  input  logic         retrig_en,
  input  logic [W-1:0] width,
  output logic         pulse,
  output logic         pulse_n
);
  localparam int STG = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic rise_s, fall_s, clr_ok;
  logic hit, accept, active;
  logic [W-1:0] cnt;

  // The rise pin resets high and the fall pin resets low, so neither
  // fires spuriously after reset. The clear chain resets to "clearing".
  os_sync #(.STAGES(STG), .RST_VAL(1'b1)) u_sync_rise (
    .clk(clk), .rst_n(rst_n), .d(rise_in), .q(rise_s));
  os_sync #(.STAGES(STG), .RST_VAL(1'b0)) u_sync_fall (
    .clk(clk), .rst_n(rst_n), .d(fall_in), .q(fall_s));
  os_sync #(.STAGES(STG), .RST_VAL(1'b0)) u_sync_clr (
    .clk(clk), .rst_n(rst_n), .d(clr_n), .q(clr_ok));

  os_trig_detect u_detect (
    .clk(clk), .rst_n(rst_n), .rise_s(rise_s), .fall_s(fall_s),
    .enable(clr_ok), .hit(hit));

  os_pulse_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_ok(clr_ok), .hit(hit),
    .mode(os_mode_e'(retrig_en)), .width(width),
    .accept(accept), .active(active), .cnt(cnt));

  // The raw clear gates the output so the pulse drops without waiting
  // for the synchronizer.
  assign pulse   = active & clr_n;
  assign pulse_n = ~pulse;
endmodule

// File: rtl/oneshot_retrig_chk.sv
module oneshot_retrig_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_n,
  input logic         retrig_en,
  input logic [W-1:0] width,
  input logic         pulse,
  input logic         clr_ok,
  input logic         accept,
  input logic         active,
  input logic [W-1:0] cnt
);
  assert_clear_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !pulse);

  assert_clear_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok |=> !active);

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cnt == $past(width)));

  assert_hold_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_en && active && clr_ok) |=> (cnt == ($past(cnt) - 1'b1)));

  assert_zero_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && width == '0) |=> !active);

  assert_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == W'(1) && !accept && clr_ok) |=> !active);
endmodule

bind oneshot_retrig oneshot_retrig_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .retrig_en(retrig_en),
  .width(width), .pulse(pulse), .clr_ok(clr_ok), .accept(accept),
  .active(active), .cnt(cnt));

// File: tb/sim_oneshot_retrig.sv
module sim_oneshot_retrig;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, rise_in, fall_in, clr_n, retrig_en;
  logic [W-1:0] width;
  logic         pulse, pulse_n;

  oneshot_retrig #(.W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rise_in(rise_in), .fall_in(fall_in),
    .clr_n(clr_n), .retrig_en(retrig_en), .width(width),
    .pulse(pulse), .pulse_n(pulse_n));

  typedef struct {
    int cyc;
    bit val;
    int req;
  } exp_t;

  exp_t sb[$];
  int   cyc    = 0;
  int   n_chk  = 0;
  int   n_bad  = 0;
  bit   done   = 1'b0;
  bit   summed = 1'b0;

  task automatic summary();
    if (!summed) begin
      summed = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  // Monitor: counts rising edges and samples 1 ns after each one.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (e.cyc != cyc || pulse !== e.val || pulse_n !== ~e.val) begin
          n_bad++;
          $display("FAIL R%0d cycle %0d: pulse=%b pulse_n=%b expected pulse=%b pulse_n=%b",
                   e.req, cyc, pulse, pulse_n, e.val, ~e.val);
        end
      end
    end
  end

  task automatic expect_span(int a, int b, bit v, int r);
    for (int k = a; k <= b; k++) begin
      exp_t e;
      e.cyc = k; e.val = v; e.req = r;
      sb.push_back(e);
    end
  endtask

  task automatic check_now(bit exp_p, string tag);
    n_chk++;
    if (pulse !== exp_p || pulse_n !== ~exp_p) begin
      n_bad++;
      $display("FAIL %s: pulse=%b pulse_n=%b expected pulse=%b pulse_n=%b",
               tag, pulse, pulse_n, exp_p, ~exp_p);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; rise_in = 1'b0; fall_in = 1'b1; clr_n = 1'b1;
    retrig_en = 1'b1; width = W'(5);
    step(3);
    rst_n = 1'b1;
    #0.5 check_now(1'b0, "R10 reset state");
    step(4);

    // R1: rise of rise_in with fall_in high, width 5 (R5 exact length)
    c0 = cyc; rise_in = 1'b1;
    expect_span(c0 + 1, c0 + 2, 1'b0, 1);
    expect_span(c0 + 3, c0 + 7, 1'b1, 1);
    expect_span(c0 + 8, c0 + 10, 1'b0, 5);
    drain();
    rise_in = 1'b0; step(4);

    // R8: valid trigger with width 0
    width = '0;
    c0 = cyc; rise_in = 1'b1;
    expect_span(c0 + 1, c0 + 8, 1'b0, 8);
    drain();

    // R2: fall of fall_in while rise_in high is ignored
    width = W'(9);
    c0 = cyc; fall_in = 1'b0;
    expect_span(c0 + 1, c0 + 8, 1'b0, 2);
    drain();
    rise_in = 1'b0; step(4);

    // R1: rise of rise_in while fall_in low is ignored
    c0 = cyc; rise_in = 1'b1;
    expect_span(c0 + 1, c0 + 8, 1'b0, 1);
    drain();
    rise_in = 1'b0; step(4);

    // R2: a rise of fall_in never triggers
    c0 = cyc; fall_in = 1'b1;
    expect_span(c0 + 1, c0 + 6, 1'b0, 2);
    drain();

    // R2: fall of fall_in with rise_in low, width 3
    width = W'(3);
    c0 = cyc; fall_in = 1'b0;
    expect_span(c0 + 3, c0 + 5, 1'b1, 2);
    expect_span(c0 + 6, c0 + 8, 1'b0, 5);
    drain();
    fall_in = 1'b1; step(4);

    // R3 + R9: retrigger reloads with the new width, no gap
    width = W'(6);
    c0 = cyc; rise_in = 1'b1;
    expect_span(c0 + 3, c0 + 10, 1'b1, 3);
    expect_span(c0 + 11, c0 + 14, 1'b0, 3);
    step(2); rise_in = 1'b0;
    step(2); rise_in = 1'b1; width = W'(4);
    drain();
    rise_in = 1'b0; step(4);

    // R4: single-shot mode ignores the second edge
    retrig_en = 1'b0; width = W'(6);
    c0 = cyc; rise_in = 1'b1;
    expect_span(c0 + 3, c0 + 8, 1'b1, 4);
    expect_span(c0 + 9, c0 + 12, 1'b0, 4);
    step(2); rise_in = 1'b0;
    step(2); rise_in = 1'b1;
    drain();
    rise_in = 1'b0; retrig_en = 1'b1; step(4);

    // R7: holding rise_in high fires once only
    width = W'(2);
    c0 = cyc; rise_in = 1'b1;
    expect_span(c0 + 3, c0 + 4, 1'b1, 7);
    expect_span(c0 + 5, c0 + 14, 1'b0, 7);
    drain();
    rise_in = 1'b0; step(4);

    // R6: clear during a 20-cycle pulse, trigger while cleared
    width = W'(20);
    c0 = cyc; rise_in = 1'b1;
    expect_span(c0 + 3, c0 + 6, 1'b1, 6);
    step(6);
    clr_n = 1'b0;
    #0.5 check_now(1'b0, "R6 immediate clear");
    expect_span(c0 + 7, c0 + 24, 1'b0, 6);
    step(2); rise_in = 1'b0;
    step(2); rise_in = 1'b1;
    step(4); clr_n = 1'b1;
    drain();
    rise_in = 1'b0; step(4);

    // R5: normal operation after clear, width 1
    width = W'(1);
    c0 = cyc; rise_in = 1'b1;
    expect_span(c0 + 3, c0 + 3, 1'b1, 5);
    expect_span(c0 + 4, c0 + 6, 1'b0, 5);
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule